// File: doc/BRIEF.md
# Read-Priority DRAM Request Scheduler with Write Batching

This block decides which memory request goes to a single-bank DRAM next, and when it goes. Read requests are load misses from the last-level cache. They enter a small read queue that keeps them in arrival order. Write requests are writebacks. They enter a separate write buffer. The scheduler tracks the row that is currently open. Within whichever class it is serving, it issues a request to that open row ahead of older requests, and otherwise it issues the oldest request.

Reads always win over writes, with two exceptions. A full write buffer starts a write batch, which drains back to back down to a low watermark. An empty read queue lets pending writes go out on their own. Each issue loads a single down counter. The counter holds the row-hit or row-conflict service time, plus the bus turnaround cost whenever the transfer direction changes. Nothing else is issued until that counter runs out.

Every issue is reported as a one-cycle pulse that carries the request's row, column, direction and hit status. A busy flag is high while the counter blocks issue.

Top module: `dram_rw_sched`

## Requirements
- R1: After synchronous reset, `busy` and `iss_valid` are 0, and both `rd_ready` and `wr_ready` are 1.
- R2: The read queue holds 8 requests. `rd_ready` is 0 while it is full. A read offered while `rd_ready` is 0 is dropped and is never issued.
- R3: The write buffer holds 8 requests. `wr_ready` is 0 while it is full.
- R4: When the write buffer is neither full nor draining, a pending read is issued before any pending write, regardless of arrival order.
- R5: Within the class being served, a request whose row equals the open row is issued before older requests. Ties, and the no-hit case, go to the oldest request. `iss_hit` is 1 exactly when the issued row equals the open row.
- R6: The first request after reset counts as a row conflict (34 cycles) and pays no turnaround cost.
- R7: Back-to-back issues are spaced by the service time of the earlier issue: 14 cycles for a row hit and 34 cycles for a row conflict. No turnaround cost applies when the direction is unchanged.
- R8: An issue that is a write and follows a read adds 2 cycles to its spacing.
- R9: An issue that is a read and follows a write adds 6 cycles to its spacing.
- R10: When the write buffer reaches 8 entries, writes are issued back to back until 2 entries remain. Reads then resume.
- R11: When the read queue is empty, a pending write is issued even if the write buffer is not full.
- R12: Each issue raises `iss_valid` for exactly one cycle, with `iss_write` (1 = write), `iss_row`, `iss_col` and `iss_hit`. `busy` is 1 in that cycle and returns to 0 once the spacing has elapsed with nothing pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_valid | input | 1 | Read request offered |
| rd_ready | output | 1 | Read queue can accept |
| rd_row | input | 12 | Row of offered read |
| rd_col | input | 10 | Column of offered read |
| wr_valid | input | 1 | Write request offered |
| wr_ready | output | 1 | Write buffer can accept |
| wr_row | input | 12 | Row of offered write |
| wr_col | input | 10 | Column of offered write |
| iss_valid | output | 1 | One-cycle issue pulse |
| iss_write | output | 1 | Issued request is a write |
| iss_row | output | 12 | Row of issued request |
| iss_col | output | 10 | Column of issued request |
| iss_hit | output | 1 | Issued request hit the open row |
| busy | output | 1 | Service or turnaround window in progress |

## Verification
A new request can be accepted into a queue on the same clock edge at which the scheduler removes another entry from that queue. The compaction shift and the append then land in the same cycle. The row-hit test provokes this: it offers its second read exactly at the edge that pops the first. The expected outcome is that the later hit read is issued before the older conflicting one, with the spacing of R5 and R7. The refusal test fills the read queue and offers one more read. That read must never appear among the issues.

// File: rtl/rws_pkg.sv
`timescale 1ns/1ps
package rws_pkg;

    localparam int ROW_W = 12;
    localparam int COL_W = 10;

    typedef logic [ROW_W-1:0] row_t;
    typedef logic [COL_W-1:0] col_t;

    typedef struct packed {
        row_t row;
        col_t col;
    } req_t;

    typedef enum logic {
        DIR_RD = 1'b0,
        DIR_WR = 1'b1
    } dir_e;

    // Turnaround applies only after something was issued and the direction flips.
    function automatic logic needs_turn(input logic started, input dir_e prev, input dir_e nxt);
        return started && (prev != nxt);
    endfunction

    function automatic int turn_cost(input dir_e nxt, input int rd2wr, input int wr2rd);
        return (nxt == DIR_WR) ? rd2wr : wr2rd;
    endfunction

endpackage

// File: rtl/rws_queue.sv
`timescale 1ns/1ps
module rws_queue import rws_pkg::*; #(
    parameter int DEPTH = 8,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push_en,
    input  req_t             push_req,
    input  logic             pop_en,
    input  row_t             open_row,
    input  logic             open_vld,
    output logic             has_room,
    output logic [CNT_W-1:0] count,
    output req_t             pick_req,
    output logic             pick_hit
);
    localparam int IDX_W = $clog2(DEPTH);

    req_t             mem [DEPTH];
    req_t             nxt [DEPTH];
    logic [DEPTH-1:0] lane_vld;
    logic [DEPTH-1:0] lane_hit;
    logic [IDX_W-1:0] sel;
    logic [CNT_W-1:0] put_cnt;

    // Slot 0 is the oldest entry; live entries are packed from slot 0 upward.
    generate
        for (genvar g = 0; g < DEPTH; g++) begin : g_lane
            assign lane_vld[g] = count > CNT_W'(g);
            assign lane_hit[g] = lane_vld[g] && open_vld && (mem[g].row == open_row);
        end
    endgenerate

    // Lowest-index hit wins; with no hit the oldest slot is chosen.
    always_comb begin
        sel      = '0;
        pick_hit = 1'b0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (lane_hit[i]) begin
                sel      = IDX_W'(i);
                pick_hit = 1'b1;
            end
        end
    end

    assign pick_req = mem[sel];
    assign has_room = count < CNT_W'(DEPTH);
    assign put_cnt  = count - CNT_W'(pop_en);

    // Close the gap left by the chosen entry, then append the arrival.
    always_comb begin
        nxt = mem;
        if (pop_en) begin
            for (int j = 0; j < DEPTH - 1; j++) begin
                if (IDX_W'(j) >= sel) begin
                    nxt[j] = mem[j + 1];
                end
            end
        end
        if (push_en) begin
            nxt[IDX_W'(put_cnt)] = push_req;
        end
    end

    always_ff @(posedge clk) begin
        mem <= nxt;
        if (rst) begin
            count <= '0;
        end else begin
            count <= count + CNT_W'(push_en) - CNT_W'(pop_en);
        end
    end

endmodule

// File: rtl/rws_timer.sv
`timescale 1ns/1ps
module rws_timer #(
    parameter int TM_W = 6
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            load,
    input  logic [TM_W-1:0] load_val,
    output logic            idle,
    output logic            busy
);
    logic [TM_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign idle = (cnt == '0);
    assign busy = !idle;

endmodule

// File: rtl/rws_ctrl.sv
`timescale 1ns/1ps
module rws_ctrl import rws_pkg::*; #(
    parameter int WR_DEPTH = 8,
    parameter int WR_LOW   = 2,
    parameter int T_HIT    = 14,
    parameter int T_MISS   = 34,
    parameter int T_RD2WR  = 2,
    parameter int T_WR2RD  = 6,
    parameter int TM_W     = 6,
    parameter int RD_CW    = 4,
    parameter int WR_CW    = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             timer_idle,
    input  logic [RD_CW-1:0] rd_count,
    input  logic [WR_CW-1:0] wr_count,
    input  req_t             rd_pick,
    input  logic             rd_hit,
    input  req_t             wr_pick,
    input  logic             wr_hit,
    output row_t             open_row,
    output logic             open_vld,
    output logic             fire,
    output logic             pop_rd,
    output logic             pop_wr,
    output logic [TM_W-1:0]  load_val,
    output logic             drain_q,
    output logic             iss_valid,
    output logic             iss_write,
    output req_t             iss_req,
    output logic             iss_hit
);
    logic rd_any;
    logic wr_any;
    logic wr_full;
    logic use_wr;
    logic drain_d;
    logic started_q;
    dir_e dir_n;
    dir_e last_dir_q;
    req_t sel_req;
    logic sel_hit;
    int   cost;

    always_comb begin
        rd_any  = rd_count != '0;
        wr_any  = wr_count != '0;
        wr_full = wr_count == WR_CW'(WR_DEPTH);
        use_wr  = wr_any && (drain_q || wr_full || !rd_any);
        fire    = timer_idle && (rd_any || wr_any);
        pop_rd  = fire && !use_wr;
        pop_wr  = fire && use_wr;
        dir_n   = use_wr ? DIR_WR : DIR_RD;
        sel_req = use_wr ? wr_pick : rd_pick;
        sel_hit = use_wr ? wr_hit : rd_hit;

        cost = sel_hit ? T_HIT : T_MISS;
        if (needs_turn(started_q, last_dir_q, dir_n)) begin
            cost = cost + turn_cost(dir_n, T_RD2WR, T_WR2RD);
        end
        // Counter holds cost-1 so the next issue lands exactly cost cycles later.
        load_val = TM_W'(cost - 1);

        drain_d = drain_q;
        if (pop_wr && (drain_q || wr_full)) begin
            drain_d = wr_count > WR_CW'(WR_LOW + 1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            drain_q    <= 1'b0;
            started_q  <= 1'b0;
            last_dir_q <= DIR_RD;
            open_row   <= '0;
            open_vld   <= 1'b0;
            iss_valid  <= 1'b0;
            iss_write  <= 1'b0;
            iss_req    <= '0;
            iss_hit    <= 1'b0;
        end else begin
            drain_q   <= drain_d;
            iss_valid <= fire;
            if (fire) begin
                open_row   <= sel_req.row;
                open_vld   <= 1'b1;
                last_dir_q <= dir_n;
                started_q  <= 1'b1;
                iss_write  <= use_wr;
                iss_req    <= sel_req;
                iss_hit    <= sel_hit;
            end
        end
    end

endmodule

// File: rtl/dram_rw_sched.sv
`timescale 1ns/1ps
module dram_rw_sched import rws_pkg::*; #(
    parameter int RD_DEPTH = 8,
    parameter int WR_DEPTH = 8,
    parameter int WR_LOW   = 2,
    parameter int T_HIT    = 14,
    parameter int T_MISS   = 34,
    parameter int T_RD2WR  = 2,
    parameter int T_WR2RD  = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rd_valid,
    output logic             rd_ready,
    input  logic [ROW_W-1:0] rd_row,
    input  logic [COL_W-1:0] rd_col,
    input  logic             wr_valid,
    output logic             wr_ready,
    input  logic [ROW_W-1:0] wr_row,
    input  logic [COL_W-1:0] wr_col,
    output logic             iss_valid,
    output logic             iss_write,
    output logic [ROW_W-1:0] iss_row,
    output logic [COL_W-1:0] iss_col,
    output logic             iss_hit,
    output logic             busy
);
    localparam int RD_CW = $clog2(RD_DEPTH + 1);
    localparam int WR_CW = $clog2(WR_DEPTH + 1);
    localparam int TM_W  = $clog2(T_MISS + T_RD2WR + T_WR2RD + 1);

    req_t             rd_in;
    req_t             wr_in;
    req_t             rd_pick;
    req_t             wr_pick;
    req_t             iss_req;
    logic             rd_hit;
    logic             wr_hit;
    logic [RD_CW-1:0] rd_count;
    logic [WR_CW-1:0] wr_count;
    row_t             open_row;
    logic             open_vld;
    logic             fire;
    logic             pop_rd;
    logic             pop_wr;
    logic             drain_q;
    logic             timer_idle;
    logic [TM_W-1:0]  load_val;

    assign rd_in = '{row: rd_row, col: rd_col};
    assign wr_in = '{row: wr_row, col: wr_col};

    rws_queue #(.DEPTH(RD_DEPTH), .CNT_W(RD_CW)) rd_q_i (
        .clk(clk), .rst(rst),
        .push_en(rd_valid && rd_ready), .push_req(rd_in), .pop_en(pop_rd),
        .open_row(open_row), .open_vld(open_vld),
        .has_room(rd_ready), .count(rd_count),
        .pick_req(rd_pick), .pick_hit(rd_hit)
    );

    rws_queue #(.DEPTH(WR_DEPTH), .CNT_W(WR_CW)) wr_q_i (
        .clk(clk), .rst(rst),
        .push_en(wr_valid && wr_ready), .push_req(wr_in), .pop_en(pop_wr),
        .open_row(open_row), .open_vld(open_vld),
        .has_room(wr_ready), .count(wr_count),
        .pick_req(wr_pick), .pick_hit(wr_hit)
    );

    rws_ctrl #(
        .WR_DEPTH(WR_DEPTH), .WR_LOW(WR_LOW),
        .T_HIT(T_HIT), .T_MISS(T_MISS), .T_RD2WR(T_RD2WR), .T_WR2RD(T_WR2RD),
        .TM_W(TM_W), .RD_CW(RD_CW), .WR_CW(WR_CW)
    ) ctrl_i (
        .clk(clk), .rst(rst), .timer_idle(timer_idle),
        .rd_count(rd_count), .wr_count(wr_count),
        .rd_pick(rd_pick), .rd_hit(rd_hit), .wr_pick(wr_pick), .wr_hit(wr_hit),
        .open_row(open_row), .open_vld(open_vld),
        .fire(fire), .pop_rd(pop_rd), .pop_wr(pop_wr), .load_val(load_val),
        .drain_q(drain_q),
        .iss_valid(iss_valid), .iss_write(iss_write), .iss_req(iss_req), .iss_hit(iss_hit)
    );

    rws_timer #(.TM_W(TM_W)) timer_i (
        .clk(clk), .rst(rst), .load(fire), .load_val(load_val),
        .idle(timer_idle), .busy(busy)
    );

    assign iss_row = iss_req.row;
    assign iss_col = iss_req.col;

endmodule

// File: rtl/rws_chk.sv
`timescale 1ns/1ps
module rws_chk import rws_pkg::*; #(
    parameter int RD_DEPTH = 8,
    parameter int WR_DEPTH = 8,
    parameter int RD_CW    = 4,
    parameter int WR_CW    = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             iss_valid,
    input logic             iss_write,
    input logic             iss_hit,
    input logic [ROW_W-1:0] iss_row,
    input logic             busy,
    input logic             drain_q,
    input logic [RD_CW-1:0] rd_count,
    input logic [WR_CW-1:0] wr_count
);
    row_t last_row_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            last_row_q <= '0;
        end else if (iss_valid) begin
            last_row_q <= iss_row;
        end
    end

    // R12
    issue_busy_chk: assert property (@(posedge clk) disable iff (rst)
        iss_valid |-> busy);

    // R12
    issue_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        iss_valid |=> !iss_valid);

    // R10
    drain_no_read_chk: assert property (@(posedge clk) disable iff (rst)
        (iss_valid && !iss_write) |-> !$past(drain_q));

    // R5
    hit_row_chk: assert property (@(posedge clk) disable iff (rst)
        (iss_valid && iss_hit) |-> (iss_row == last_row_q));

    // R2
    rd_no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        rd_count <= RD_CW'(RD_DEPTH));

    // R3
    wr_no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        wr_count <= WR_CW'(WR_DEPTH));

endmodule

bind dram_rw_sched rws_chk #(
    .RD_DEPTH(RD_DEPTH), .WR_DEPTH(WR_DEPTH), .RD_CW(RD_CW), .WR_CW(WR_CW)
) chk_i (
    .clk(clk), .rst(rst), .iss_valid(iss_valid), .iss_write(iss_write),
    .iss_hit(iss_hit), .iss_row(iss_row), .busy(busy), .drain_q(drain_q),
    .rd_count(rd_count), .wr_count(wr_count)
);

// File: tb/dram_rw_sched_tb_top.sv
`timescale 1ns/1ps
module dram_rw_sched_tb_top;
    import rws_pkg::*;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             rd_valid = 1'b0;
    logic             rd_ready;
    logic [ROW_W-1:0] rd_row = '0;
    logic [COL_W-1:0] rd_col = '0;
    logic             wr_valid = 1'b0;
    logic             wr_ready;
    logic [ROW_W-1:0] wr_row = '0;
    logic [COL_W-1:0] wr_col = '0;
    logic             iss_valid;
    logic             iss_write;
    logic [ROW_W-1:0] iss_row;
    logic [COL_W-1:0] iss_col;
    logic             iss_hit;
    logic             busy;

    always #4 clk = ~clk;

    dram_rw_sched dut_i (
        .clk(clk), .rst(rst),
        .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_row(rd_row), .rd_col(rd_col),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_row(wr_row), .wr_col(wr_col),
        .iss_valid(iss_valid), .iss_write(iss_write), .iss_row(iss_row),
        .iss_col(iss_col), .iss_hit(iss_hit), .busy(busy)
    );

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int log_n = 0;
    int log_cyc [64];
    int log_row [64];
    int log_col [64];
    int log_wr  [64];
    int log_hit [64];
    int log_bsy [64];

    always @(posedge clk) cyc <= cyc + 1;

    // Issue recorder, sampled mid-cycle.
    always @(negedge clk) begin
        if (rst) begin
            log_n = 0;
        end else if (iss_valid && log_n < 64) begin
            log_cyc[log_n] = cyc;
            log_row[log_n] = int'(iss_row);
            log_col[log_n] = int'(iss_col);
            log_wr[log_n]  = int'(iss_write);
            log_hit[log_n] = int'(iss_hit);
            log_bsy[log_n] = int'(busy);
            log_n = log_n + 1;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; rd_valid = 1'b0; wr_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic push_rd(input int row, input int col);
        @(negedge clk);
        rd_valid = 1'b1; wr_valid = 1'b0;
        rd_row = ROW_W'(row); rd_col = COL_W'(col);
    endtask

    task automatic push_wr(input int row, input int col);
        @(negedge clk);
        wr_valid = 1'b1; rd_valid = 1'b0;
        wr_row = ROW_W'(row); wr_col = COL_W'(col);
    endtask

    task automatic quiet();
        @(negedge clk);
        rd_valid = 1'b0; wr_valid = 1'b0;
    endtask

    task automatic wait_issues(input string tag, input int n);
        int t = 0;
        while (log_n < n && t < 3000) begin
            @(posedge clk);
            t++;
        end
        @(posedge clk);
        chk({tag, " issue count"}, log_n, n);
    endtask

    function automatic int gap(input int k);
        return log_cyc[k] - log_cyc[k - 1];
    endfunction

    task automatic test_reset();
        do_reset();
        @(negedge clk);
        chk("R1 busy", int'(busy), 0);
        chk("R1 iss_valid", int'(iss_valid), 0);
        chk("R1 rd_ready", int'(rd_ready), 1);
        chk("R1 wr_ready", int'(wr_ready), 1);
    endtask

    task automatic test_row_hit();
        do_reset();
        push_rd(1, 1);
        push_rd(3, 1);   // accepted on the edge that pops the first read
        push_rd(1, 5);
        quiet();
        wait_issues("R5", 3);
        chk("R6 first hit flag", log_hit[0], 0);
        chk("R6 first spacing", gap(1), 34);
        chk("R5 hit row chosen", log_col[1], 5);
        chk("R5 hit flag", log_hit[1], 1);
        chk("R7 hit spacing", gap(2), 14);
        chk("R5 older conflict last", log_row[2], 3);
        chk("R12 busy at issue", log_bsy[0], 1);
        repeat (40) @(negedge clk);
        chk("R12 busy clears", int'(busy), 0);
        chk("R12 single pulse", log_n, 3);
    endtask

    task automatic test_wr_then_rd();
        do_reset();
        push_wr(9, 0);
        push_rd(9, 1);
        push_rd(9, 2);
        quiet();
        wait_issues("R11", 3);
        chk("R11 lone write issued", log_wr[0], 1);
        chk("R6 write first spacing", gap(1), 34);
        chk("R9 write to read spacing", gap(2), 20);
        chk("R9 read is hit", log_hit[1], 1);
    endtask

    task automatic test_rd_then_wr();
        do_reset();
        push_rd(2, 0);
        push_wr(2, 1);
        push_wr(2, 2);
        push_wr(2, 3);
        quiet();
        wait_issues("R8", 4);
        chk("R8 second is write", log_wr[1], 1);
        chk("R7 read conflict spacing", gap(1), 34);
        chk("R8 read to write spacing", gap(2), 16);
        chk("R7 write hit spacing", gap(3), 14);
    endtask

    task automatic test_read_first();
        do_reset();
        push_rd(1, 0);
        push_wr(7, 0);
        push_rd(8, 0);
        quiet();
        wait_issues("R4", 3);
        chk("R4 younger read first", log_row[1], 8);
        chk("R4 read dir", log_wr[1], 0);
        chk("R4 write after", log_wr[2], 1);
    endtask

    task automatic test_drain();
        int exp_row [10] = '{10, 10, 11, 12, 13, 14, 20, 21, 15, 16};
        int exp_wr  [10] = '{1, 1, 1, 1, 1, 1, 0, 0, 1, 1};
        do_reset();
        push_rd(1, 0);
        push_wr(10, 0);
        push_wr(11, 0);
        push_wr(10, 1);
        push_wr(12, 0);
        push_wr(13, 0);
        push_wr(14, 0);
        push_wr(15, 0);
        push_wr(16, 0);
        push_rd(20, 0);
        push_rd(21, 0);
        quiet();
        chk("R3 wr_ready full", int'(wr_ready), 0);
        wait_issues("R10", 11);
        for (int k = 0; k < 10; k++) begin
            chk($sformatf("R10 row of issue %0d", k + 1), log_row[k + 1], exp_row[k]);
            chk($sformatf("R10 dir of issue %0d", k + 1), log_wr[k + 1], exp_wr[k]);
        end
        chk("R3 wr_ready after", int'(wr_ready), 1);
    endtask

    task automatic test_rd_full();
        do_reset();
        for (int r = 30; r < 39; r++) begin
            push_rd(r, 0);
        end
        @(negedge clk);
        chk("R2 rd_ready full", int'(rd_ready), 0);
        rd_row = ROW_W'(39); rd_valid = 1'b1;
        quiet();
        wait_issues("R2", 9);
        repeat (60) @(negedge clk);
        chk("R2 refused not issued", log_n, 9);
        chk("R2 last accepted row", log_row[8], 38);
        chk("R2 rd_ready after", int'(rd_ready), 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual %0d expected %0d", cyc, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        test_reset();
        test_row_hit();
        test_wr_then_rd();
        test_rd_then_wr();
        test_read_first();
        test_drain();
        test_rd_full();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule